// File: doc/BRIEF.md
# Shared Mailbox Lock and Execute Controller

This block arbitrates a shared mailbox buffer between several bus requesters and an internal microcontroller. A requester claims the mailbox by reading the lock register. If the mailbox is free, that read returns 0, grants the lock and records the requester's bus user ID as the owner. While the lock is held, only the owner may write the command word, the data length, the execute flag or the buffer contents. Every other requester gets a bus error, and its write is discarded.

When the owner sets the execute flag, the microcontroller receives a one-cycle interrupt. When the owner later clears the flag, the mailbox returns to idle and the owner ID is wiped. The microcontroller can force a release at any time to recover from a stuck owner or a deadlock.

Buffer accesses are bounds-checked against a capacity chosen by the operating-mode input: a large buffer in passive mode and a small one in subsystem mode. An offset past the limit is refused. It never folds back onto a lower word. The buffer SRAM sits outside this block on a simple port with a read latency of one cycle.

Top module: `mbox_lock_ctrl`

## Requirements
- R1: After reset the lock is free, the owner ID is 0, execute is clear, and both `uc_irq` and `rsp_valid` are low.
- R2: A read of the lock register (sel 0) while the mailbox is free returns 0 and takes the lock. From the next cycle, the owner is the reading requester's user ID.
- R3: A read of the lock register while the lock is held returns 1 with no error, and leaves the lock and the owner unchanged. This holds for every user ID, including the owner's.
- R4: Writes to command (sel 2), data length (sel 3), execute (sel 4) and buffer data (sel 5) are accepted only from the current owner while locked. Any other such write returns an error and changes nothing.
- R5: An accepted execute write with bit 0 = 1 while execute is clear raises `uc_irq` for exactly one cycle, the response cycle. Setting execute again while it is already set raises no interrupt.
- R6: An accepted execute write with bit 0 = 0 while execute is set releases the lock, clears execute and sets the owner ID to 0.
- R7: A one-cycle pulse on `uc_force_rel` leaves the lock free, execute clear and the owner ID 0 on the following cycle. This applies whatever state the mailbox was in.
- R8: Buffer capacity is PASS_BYTES when `mode_subsys` = 0 and SUB_BYTES when it is 1. A buffer access whose byte offset is at or beyond the capacity returns an error and issues no memory access. An access inside the capacity reaches word address offset/4.
- R9: Register select encoding: 0 lock, 1 owner ID (read-only), 2 command, 3 data length, 4 execute (bit 0), 5 buffer data. A write to sel 0 or 1, or any access to sel 6 or 7, returns an error.
- R10: Every request gets exactly one response, with `rsp_valid` high in the cycle after the request. Reads of sel 1 to 4 are allowed from any user ID.
- R11: A buffer read (sel 5) from a requester that is not the owner returns an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_subsys | input | 1 | Operating mode: 0 passive (large buffer), 1 subsystem (small buffer) |
| soc_req | input | 1 | Request strobe, one cycle per access |
| soc_wr | input | 1 | 1 write, 0 read |
| soc_sel | input | 3 | Register select |
| soc_ofs | input | OFS_W | Buffer byte offset for sel 5 |
| soc_wdata | input | DATA_W | Write data |
| soc_user | input | USER_W | Requester bus user ID |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | DATA_W | Read data |
| uc_force_rel | input | 1 | Microcontroller forced release of the lock |
| uc_irq | output | 1 | Command-ready interrupt pulse |
| mem_en | output | 1 | Buffer SRAM enable |
| mem_we | output | 1 | Buffer SRAM write enable |
| mem_addr | output | MA_W | Buffer SRAM word address |
| mem_wdata | output | DATA_W | Buffer SRAM write data |
| mem_rdata | input | DATA_W | Buffer SRAM read data, one cycle after enable |
| lock_held | output | 1 | Lock currently held |
| lock_owner | output | USER_W | User ID of the lock holder, 0 when free |
| exec_pending | output | 1 | Execute flag |

## Verification
The case that is hardest to reach from the ports is an out-of-range buffer write that would silently alias onto a valid word. It shows up only as corrupted contents, seen later. To expose it, the bench fills every word in range with a pattern derived from its offset. It then sweeps offsets past the limit with a different pattern, in both modes, and reads the whole range back. It also reads the large-mode words from 16 bytes upward after the small-mode sweep, to show that subsystem mode did not leak writes beyond its limit. Ownership is checked by sweeping all user IDs against a held lock.

// File: rtl/mbox_lock_ctrl.sv
module mbox_lock_ctrl #(
  parameter int USER_W     = 8,
  parameter int DATA_W     = 32,
  parameter int PASS_BYTES = 262144,
  parameter int SUB_BYTES  = 16384,
  localparam int OFS_W     = $clog2(PASS_BYTES) + 1,
  localparam int MA_W      = $clog2(PASS_BYTES) - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_subsys,
  input  logic              soc_req,
  input  logic              soc_wr,
  input  logic [2:0]        soc_sel,
  input  logic [OFS_W-1:0]  soc_ofs,
  input  logic [DATA_W-1:0] soc_wdata,
  input  logic [USER_W-1:0] soc_user,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              uc_force_rel,
  output logic              uc_irq,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              lock_held,
  output logic [USER_W-1:0] lock_owner,
  output logic              exec_pending
);

  localparam logic [2:0] SEL_LOCK = 3'd0;
  localparam logic [2:0] SEL_OWN  = 3'd1;
  localparam logic [2:0] SEL_CMD  = 3'd2;
  localparam logic [2:0] SEL_LEN  = 3'd3;
  localparam logic [2:0] SEL_EXE  = 3'd4;
  localparam logic [2:0] SEL_DAT  = 3'd5;
  localparam logic [OFS_W-1:0] CAP_PASS = OFS_W'(PASS_BYTES);
  localparam logic [OFS_W-1:0] CAP_SUB  = OFS_W'(SUB_BYTES);

  logic              lock_q, exec_q, irq_q;
  logic [USER_W-1:0] owner_q;
  logic [DATA_W-1:0] cmd_q, len_q, rdata_q;
  logic              vld_q, err_q, memrd_q;

  logic              err_d, grant, cmd_we, len_we, exe_we, acc_ok;
  logic [DATA_W-1:0] rdata_d;

  wire [OFS_W-1:0] cap      = mode_subsys ? CAP_SUB : CAP_PASS;
  wire             in_range = soc_ofs < cap;
  wire             is_owner = lock_q && (soc_user == owner_q);

  always_comb begin
    err_d   = 1'b0;
    grant   = 1'b0;
    cmd_we  = 1'b0;
    len_we  = 1'b0;
    exe_we  = 1'b0;
    acc_ok  = 1'b0;
    rdata_d = '0;
    if (soc_req) begin
      case (soc_sel)
        SEL_LOCK: begin
          if (soc_wr) err_d = 1'b1;
          else begin
            rdata_d = DATA_W'(lock_q);
            grant   = !lock_q;
          end
        end
        SEL_OWN: begin
          if (soc_wr) err_d = 1'b1;
          else rdata_d = DATA_W'(owner_q);
        end
        SEL_CMD: begin
          if (!soc_wr) rdata_d = cmd_q;
          else if (is_owner) cmd_we = 1'b1;
          else err_d = 1'b1;
        end
        SEL_LEN: begin
          if (!soc_wr) rdata_d = len_q;
          else if (is_owner) len_we = 1'b1;
          else err_d = 1'b1;
        end
        SEL_EXE: begin
          if (!soc_wr) rdata_d = DATA_W'(exec_q);
          else if (is_owner) exe_we = 1'b1;
          else err_d = 1'b1;
        end
        SEL_DAT: begin
          if (is_owner && in_range) acc_ok = 1'b1;
          else err_d = 1'b1;
        end
        default: err_d = 1'b1;
      endcase
    end
  end

  assign mem_en    = acc_ok;
  assign mem_we    = acc_ok && soc_wr;
  assign mem_addr  = soc_ofs[OFS_W-2:2];
  assign mem_wdata = soc_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      exec_q  <= 1'b0;
      owner_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= !uc_force_rel && exe_we && soc_wdata[0] && !exec_q;
      if (uc_force_rel) begin
        lock_q  <= 1'b0;
        exec_q  <= 1'b0;
        owner_q <= '0;
      end else if (grant) begin
        lock_q  <= 1'b1;
        owner_q <= soc_user;
      end else if (exe_we) begin
        if (soc_wdata[0]) exec_q <= 1'b1;
        else if (exec_q) begin
          lock_q  <= 1'b0;
          exec_q  <= 1'b0;
          owner_q <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      len_q <= '0;
    end else begin
      if (cmd_we) cmd_q <= soc_wdata;
      if (len_we) len_q <= soc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      memrd_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      vld_q   <= soc_req;
      err_q   <= err_d;
      memrd_q <= acc_ok && !soc_wr;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_valid    = vld_q;
  assign rsp_err      = err_q;
  assign rsp_rdata    = memrd_q ? mem_rdata : rdata_q;
  assign uc_irq       = irq_q;
  assign lock_held    = lock_q;
  assign lock_owner   = owner_q;
  assign exec_pending = exec_q;

  // R6
  exec_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_q |-> lock_q);

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uc_irq |=> !uc_irq);

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soc_req |=> rsp_valid);

  // R8
  range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soc_req && soc_sel == SEL_DAT && !in_range) |=> rsp_err);

  // R8
  no_oob_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (soc_ofs < cap));

  // R4
  foreign_cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soc_req && soc_wr && soc_sel == SEL_CMD && !is_owner) |=> ($stable(cmd_q) && rsp_err));

  // R7
  force_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uc_force_rel |=> (!lock_held && !exec_pending && lock_owner == '0));

  // R2
  grant_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soc_req && !soc_wr && soc_sel == SEL_LOCK && !lock_q && !uc_force_rel)
      |=> (lock_held && lock_owner == $past(soc_user) && rsp_rdata == '0));

  // R3
  held_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soc_req && !soc_wr && soc_sel == SEL_LOCK && lock_q) |=> (rsp_rdata == DATA_W'(1)));

endmodule

// File: tb/sim_mbox_lock_ctrl.sv
module sim_mbox_lock_ctrl;
  localparam int UW = 4, DW = 32, PB = 64, SB = 16;
  localparam int OW = $clog2(PB) + 1, MW = $clog2(PB) - 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_subsys = 1'b0, soc_req = 1'b0, soc_wr = 1'b0, uc_force_rel = 1'b0;
  logic [2:0] soc_sel = '0;
  logic [OW-1:0] soc_ofs = '0;
  logic [DW-1:0] soc_wdata = '0;
  logic [UW-1:0] soc_user = '0;
  logic rsp_valid, rsp_err, uc_irq, mem_en, mem_we, lock_held, exec_pending;
  logic [DW-1:0] rsp_rdata, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [MW-1:0] mem_addr;
  logic [UW-1:0] lock_owner;
  logic [DW-1:0] ram [0:(1<<MW)-1];

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mbox_lock_ctrl #(.USER_W(UW), .DATA_W(DW), .PASS_BYTES(PB), .SUB_BYTES(SB)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_subsys(mode_subsys), .soc_req(soc_req),
    .soc_wr(soc_wr), .soc_sel(soc_sel), .soc_ofs(soc_ofs), .soc_wdata(soc_wdata),
    .soc_user(soc_user), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .uc_force_rel(uc_force_rel), .uc_irq(uc_irq),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .lock_held(lock_held), .lock_owner(lock_owner),
    .exec_pending(exec_pending));

  always @(posedge clk) begin
    if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_en) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  bit a_err, a_irq;
  logic [DW-1:0] a_rd;

  task automatic acc(input logic [2:0] sel, input logic wr, input logic [OW-1:0] ofs,
                     input logic [DW-1:0] wd, input logic [UW-1:0] usr);
    @(negedge clk);
    soc_sel = sel; soc_wr = wr; soc_ofs = ofs; soc_wdata = wd; soc_user = usr;
    soc_req = 1'b1;
    @(negedge clk);
    soc_req = 1'b0;
    a_err = rsp_err; a_rd = rsp_rdata; a_irq = uc_irq;
    if (!rsp_valid) begin
      vecs++; errs++;
      $display("FAIL R10 actual=0 expected=1 (rsp_valid)");
    end
  endtask

  function automatic logic [DW-1:0] pat(input int m, input int o);
    return 32'h1000_0000 ^ (m << 16) ^ o;
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lock", lock_held, 0);
    chk("R1 owner", lock_owner, 0);
    chk("R1 exec", exec_pending, 0);
    chk("R1 irq", uc_irq, 0);
    chk("R1 rsp_valid", rsp_valid, 0);

    acc(3'd0, 0, '0, '0, 4'd5);
    chk("R2 lock rd", a_rd, 0);
    chk("R2 err", a_err, 0);
    chk("R2 held", lock_held, 1);
    chk("R2 owner", lock_owner, 5);
    @(negedge clk);
    chk("R10 rsp_valid drops", rsp_valid, 0);

    for (int u = 0; u < 16; u++) begin
      acc(3'd0, 0, '0, '0, UW'(u));
      chk("R3 lock rd", a_rd, 1);
      chk("R3 err", a_err, 0);
      chk("R3 owner kept", lock_owner, 5);
    end

    acc(3'd1, 0, '0, '0, 4'd9);
    chk("R9 owner reg", a_rd, 5);
    chk("R10 read by other", a_err, 0);
    acc(3'd0, 1, '0, 32'h0, 4'd5);
    chk("R9 wr lock err", a_err, 1);
    acc(3'd1, 1, '0, 32'h3, 4'd5);
    chk("R9 wr owner err", a_err, 1);
    chk("R9 owner unchanged", lock_owner, 5);
    acc(3'd6, 0, '0, '0, 4'd5);
    chk("R9 sel6 err", a_err, 1);
    acc(3'd7, 1, '0, '0, 4'd5);
    chk("R9 sel7 err", a_err, 1);

    acc(3'd2, 1, '0, 32'hA5, 4'd5);
    chk("R4 owner cmd", a_err, 0);
    acc(3'd3, 1, '0, 32'h40, 4'd5);
    chk("R4 owner len", a_err, 0);
    for (int u = 0; u < 16; u++) begin
      if (u == 5) continue;
      acc(3'd2, 1, '0, DW'(u), UW'(u));
      chk("R4 foreign cmd err", a_err, 1);
      acc(3'd3, 1, '0, DW'(u), UW'(u));
      chk("R4 foreign len err", a_err, 1);
      acc(3'd4, 1, '0, 32'h1, UW'(u));
      chk("R4 foreign exec err", a_err, 1);
      chk("R4 exec unchanged", exec_pending, 0);
      acc(3'd5, 1, 7'd0, 32'hDEAD, UW'(u));
      chk("R4 foreign data err", a_err, 1);
      acc(3'd5, 0, 7'd0, '0, UW'(u));
      chk("R11 foreign data rd err", a_err, 1);
    end
    acc(3'd2, 0, '0, '0, 4'd1);
    chk("R4 cmd kept", a_rd, 32'hA5);
    acc(3'd3, 0, '0, '0, 4'd1);
    chk("R4 len kept", a_rd, 32'h40);

    for (int m = 0; m < 2; m++) begin
      mode_subsys = m[0];
      for (int o = 0; o < 128; o += 4) begin
        acc(3'd5, 1, OW'(o), pat(m, o), 4'd5);
        chk("R8 wr err", a_err, (o >= (m ? SB : PB)) ? 1 : 0);
      end
      for (int o = 0; o < (m ? SB : PB); o += 4) begin
        acc(3'd5, 0, OW'(o), '0, 4'd5);
        chk("R8 rd err", a_err, 0);
        chk("R8 rd data", a_rd, pat(m, o));
      end
      for (int o = (m ? SB : PB); o < 128; o += 4) begin
        acc(3'd5, 0, OW'(o), '0, 4'd5);
        chk("R8 oob rd err", a_err, 1);
      end
    end
    mode_subsys = 1'b0;
    for (int o = SB; o < PB; o += 4) begin
      acc(3'd5, 0, OW'(o), '0, 4'd5);
      chk("R8 no leak", a_rd, pat(0, o));
    end

    acc(3'd4, 1, '0, 32'h1, 4'd5);
    chk("R5 exec err", a_err, 0);
    chk("R5 irq", a_irq, 1);
    chk("R5 exec set", exec_pending, 1);
    @(negedge clk);
    chk("R5 irq one cycle", uc_irq, 0);
    acc(3'd4, 1, '0, 32'h1, 4'd5);
    chk("R5 no second irq", a_irq, 0);
    acc(3'd4, 0, '0, '0, 4'd3);
    chk("R10 exec read", a_rd, 1);

    acc(3'd4, 1, '0, 32'h0, 4'd5);
    chk("R6 err", a_err, 0);
    chk("R6 unlocked", lock_held, 0);
    chk("R6 owner", lock_owner, 0);
    chk("R6 exec", exec_pending, 0);
    acc(3'd2, 1, '0, 32'h77, 4'd5);
    chk("R4 unlocked wr err", a_err, 1);

    acc(3'd0, 0, '0, '0, 4'd2);
    chk("R2 regrant", a_rd, 0);
    acc(3'd4, 1, '0, 32'h1, 4'd2);
    chk("R5 irq again", a_irq, 1);
    @(negedge clk);
    uc_force_rel = 1'b1;
    @(negedge clk);
    uc_force_rel = 1'b0;
    chk("R7 unlocked", lock_held, 0);
    chk("R7 exec", exec_pending, 0);
    chk("R7 owner", lock_owner, 0);
    acc(3'd0, 0, '0, '0, 4'd9);
    chk("R7 free after force", a_rd, 0);
    chk("R7 new owner", lock_owner, 9);
    @(negedge clk);
    uc_force_rel = 1'b1;
    @(negedge clk);
    uc_force_rel = 1'b0;
    chk("R7 force no exec", lock_held, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule